// File: doc/BRIEF.md
# Mode-Controlled GPIO Port

An eight-pin general-purpose I/O port. Each pin carries a two-bit mode code that routes it to an alternate-function peripheral, drives it from a bus-written data latch, or turns it into an input with the pull-up either on or off. The block drives the pad's output value, output enable and pull-up enable. A small register bus writes and reads back a data latch and a mode register.

The mode also decides what a bus read of the data address returns. Pins in the alternate or output mode return the latched bit. Pins in either input mode return the pad level after it has passed a two-flop synchroniser. A write to the data address always updates the latch. The new value reaches the pad only for pins in output mode, so software can preload a value before it turns a pin into an output.

The register bus is plain control wiring and has no valid/ready handshake. A write takes effect on the clock edge on which the single-cycle strobe is high, and the port never applies back-pressure. Read data is combinational from the select bit and the current register and synchroniser state.

Top module: `gpio_mode_port`

## Requirements
- R1: After reset the data latch reads 0 and every mode code reads 00, so every pin starts in alternate-function mode. The synchronised pin levels also reset to 0.
- R2: A write with `bus_sel`=1 stores `bus_wdata[15:0]` as the mode register, with pin n's code in bits [2n+1:2n]. Reading with `bus_sel`=1 returns that register.
- R3: A pin with mode 00 passes `alt_out[n]` and `alt_oe[n]` to `pin_out[n]` and `pin_oe[n]`, and its pull-up enable is 0.
- R4: A pin with mode 01 has `pin_oe[n]`=1 and `pin_out[n]` equal to latch bit n, and its pull-up enable is 0.
- R5: A pin with mode 10 or 11 has `pin_oe[n]`=0 and `pin_out[n]`=0. `pin_pu[n]` is 1 for mode 10 and 0 for mode 11.
- R6: With `bus_sel`=0, bit n of `bus_rdata` returns latch bit n for a pin in mode 00 or 01.
- R7: With `bus_sel`=0, bit n of `bus_rdata` returns the synchronised pin level for a pin in mode 10 or 11. A change on `pin_in` becomes visible after the second rising clock edge that follows it, and not after the first.
- R8: A write with `bus_sel`=0 stores `bus_wdata[7:0]` in the latch in every mode. The stored value changes the pad outputs only for pins in mode 01.
- R9: When a pin is switched to mode 01, it drives at once the latch value last written, even if that write happened while the pin was in an input mode.
- R10: `bus_rdata` is valid combinationally in the cycle in which `bus_sel` is applied. With `bus_sel`=0, `bus_rdata[15:8]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_sel | input | 1 | Register select: 0 selects the data latch, 1 selects the mode register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| alt_out | input | 8 | Alternate-function output values |
| alt_oe | input | 8 | Alternate-function output enables |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |

## Verification
Two functions can act in the same cycle: a data-latch write and a change of the synchronised pin level on a pin in input mode. The bench provokes this by changing `pin_in` and writing a different value to the latch on the same edge while all pins are in mode 10. Two clocks later a read must return the pin level and not the written value, and the pads must stay undriven. The pins are then switched to mode 01, and the pads must show at once the value written while the pins were inputs.

// File: rtl/gpio_mode_pkg.sv
package gpio_mode_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_ALT     = 2'b00,
    PM_DRIVE   = 2'b01,
    PM_IN_PU   = 2'b10,
    PM_IN_FLT  = 2'b11
  } pin_mode_e;

  function automatic logic is_input_mode(input pin_mode_e m);
    return (m == PM_IN_PU) || (m == PM_IN_FLT);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter  int PINS  = 8,
  localparam int BUS_W = 2 * PINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [BUS_W-1:0] wdata,
  output logic [PINS-1:0]  latch_q,
  output logic [BUS_W-1:0] mode_q
);

  logic latch_we;
  logic mode_we;

  assign latch_we = we && !sel;
  assign mode_we  = we &&  sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_we) latch_q <= wdata[PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= wdata;
  end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_mode_pkg::*;
(
  input  logic [MODE_W-1:0] mode_bits,
  input  logic              latch_bit,
  input  logic              sync_bit,
  input  logic              alt_val,
  input  logic              alt_en,
  output logic              pad_val,
  output logic              pad_en,
  output logic              pad_pull,
  output logic              rd_bit
);

  pin_mode_e mode;
  assign mode = pin_mode_e'(mode_bits);

  always_comb begin
    pad_val  = 1'b0;
    pad_en   = 1'b0;
    pad_pull = 1'b0;
    unique case (mode)
      PM_ALT: begin
        pad_val = alt_val;
        pad_en  = alt_en;
      end
      PM_DRIVE: begin
        pad_val = latch_bit;
        pad_en  = 1'b1;
      end
      PM_IN_PU:  pad_pull = 1'b1;
      PM_IN_FLT: pad_pull = 1'b0;
      default: ;
    endcase
  end

  assign rd_bit = is_input_mode(mode) ? sync_bit : latch_bit;

endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
  import gpio_mode_pkg::*;
#(
  parameter  int PINS        = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int BUS_W       = MODE_W * PINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_sel,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [PINS-1:0]  pin_in,
  input  logic [PINS-1:0]  alt_out,
  input  logic [PINS-1:0]  alt_oe,
  output logic [PINS-1:0]  pin_out,
  output logic [PINS-1:0]  pin_oe,
  output logic [PINS-1:0]  pin_pu
);

  logic [PINS-1:0]  latch_q;
  logic [BUS_W-1:0] mode_q;
  logic [PINS-1:0]  pin_sync;
  logic [PINS-1:0]  rd_bits;

  gpio_port_regs #(.PINS(PINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we),
    .sel     (bus_sel),
    .wdata   (bus_wdata),
    .latch_q (latch_q),
    .mode_q  (mode_q)
  );

  gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  generate
    for (genvar n = 0; n < PINS; n++) begin : g_pin
      gpio_pin_cell u_cell (
        .mode_bits (mode_q[MODE_W*n +: MODE_W]),
        .latch_bit (latch_q[n]),
        .sync_bit  (pin_sync[n]),
        .alt_val   (alt_out[n]),
        .alt_en    (alt_oe[n]),
        .pad_val   (pin_out[n]),
        .pad_en    (pin_oe[n]),
        .pad_pull  (pin_pu[n]),
        .rd_bit    (rd_bits[n])
      );
    end
  endgenerate

  assign bus_rdata = bus_sel ? mode_q : {{(BUS_W-PINS){1'b0}}, rd_bits};

endmodule

// File: rtl/gpio_mode_port_chk.sv
module gpio_mode_port_chk #(
  parameter  int PINS        = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int BUS_W       = 2 * PINS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic             bus_sel,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [PINS-1:0]  pin_in,
  input logic [PINS-1:0]  alt_oe,
  input logic [PINS-1:0]  pin_out,
  input logic [PINS-1:0]  pin_oe,
  input logic [PINS-1:0]  pin_pu
);

  logic [BUS_W-1:0] sh_mode;
  logic [PINS-1:0]  sh_chain [SYNC_STAGES];
  logic [PINS-1:0]  alt_m, out_m, in_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sh_mode <= '0;
    else if (bus_we && bus_sel) sh_mode <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sh_chain[s] <= '0;
    end else begin
      sh_chain[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) sh_chain[s] <= sh_chain[s-1];
    end
  end

  always_comb begin
    for (int n = 0; n < PINS; n++) begin
      alt_m[n] = (sh_mode[2*n +: 2] == 2'b00);
      out_m[n] = (sh_mode[2*n +: 2] == 2'b01);
      in_m[n]  = sh_mode[2*n+1];
    end
  end

  AST_PULL_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0); // R5
  AST_DRIVE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & out_m) == out_m); // R4
  AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & in_m) == '0); // R5
  AST_ALT_ENABLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe ^ alt_oe) & alt_m) == '0); // R3
  AST_PIN_READ_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> ((bus_rdata[PINS-1:0] ^ sh_chain[SYNC_STAGES-1]) & in_m) == '0); // R7
  AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata[BUS_W-1:PINS] == '0); // R10
  AST_LATCH_TO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_sel) |=> ((pin_out ^ $past(bus_wdata[PINS-1:0])) & out_m) == '0); // R8
  AST_MODE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel) |=> (!bus_sel || bus_rdata == $past(bus_wdata))); // R2

endmodule

bind gpio_mode_port gpio_mode_port_chk #(.PINS(PINS), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_sel   (bus_sel),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .alt_oe    (alt_oe),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_pu    (pin_pu)
);

// File: tb/gpio_mode_port_bench.sv
`timescale 1ns/1ps
module gpio_mode_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_sel = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  alt_out = '0;
  logic [7:0]  alt_oe = '0;
  logic [7:0]  pin_out, pin_oe, pin_pu;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0]  m_latch = '0;
  logic [15:0] m_mode  = '0;

  always #5 clk = ~clk;

  gpio_mode_port u_gpio_mode_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .alt_out(alt_out), .alt_oe(alt_oe), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] v);
    bus_we = 1'b1; bus_sel = sel; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0; bus_sel = 1'b0; bus_wdata = '0;
    if (sel) m_mode = v; else m_latch = v[7:0];
  endtask

  // expected pad and read values from the mode table in the requirements
  task automatic check_all(input string req, input logic [7:0] pins_settled);
    logic [7:0] e_out, e_oe, e_pu, e_rd;
    for (int n = 0; n < 8; n++) begin
      case (m_mode[2*n +: 2])
        2'b00:   begin e_out[n] = alt_out[n]; e_oe[n] = alt_oe[n]; e_pu[n] = 0; e_rd[n] = m_latch[n]; end
        2'b01:   begin e_out[n] = m_latch[n]; e_oe[n] = 1;         e_pu[n] = 0; e_rd[n] = m_latch[n]; end
        2'b10:   begin e_out[n] = 0;          e_oe[n] = 0;         e_pu[n] = 1; e_rd[n] = pins_settled[n]; end
        default: begin e_out[n] = 0;          e_oe[n] = 0;         e_pu[n] = 0; e_rd[n] = pins_settled[n]; end
      endcase
    end
    bus_sel = 1'b0; #1;
    chk({req, " read"}, bus_rdata, {8'h00, e_rd});
    chk({req, " pin_out"}, {8'h00, pin_out}, {8'h00, e_out});
    chk({req, " pin_oe"},  {8'h00, pin_oe},  {8'h00, e_oe});
    chk({req, " pin_pu"},  {8'h00, pin_pu},  {8'h00, e_pu});
  endtask

  initial begin
    logic [7:0] pv;
    // R1 reset state
    alt_out = 8'h96; alt_oe = 8'h3C; pin_in = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_sel = 1'b0; #1;
    chk("R1 latch", bus_rdata, 16'h0000);
    chk("R1 R3 pin_oe", {8'h00, pin_oe}, {8'h00, alt_oe});
    chk("R1 R3 pin_out", {8'h00, pin_out}, {8'h00, alt_out});
    chk("R1 pin_pu", {8'h00, pin_pu}, 16'h0000);
    bus_sel = 1'b1; #1;
    chk("R1 mode", bus_rdata, 16'h0000);
    bus_sel = 1'b0;
    @(negedge clk);

    // R2 mode register read-back at the same cycle as the select (R10)
    foreach (pv[k]) begin
      wr(1'b1, 16'h1 << (2*k) | 16'hA000 >> k);
      bus_sel = 1'b1; #1;
      chk("R2 R10 mode read", bus_rdata, m_mode);
      bus_sel = 1'b0;
      @(negedge clk);
    end

    // uniform-mode sweeps over all latch values: R3 R4 R5 R6 R7 R8
    for (int m = 0; m < 4; m++) begin
      wr(1'b1, {8{m[1:0]}});
      for (int d = 0; d < 256; d++) begin
        pv = {d[3:0], d[7:4]} ^ 8'hC3;
        pin_in = pv; alt_out = ~d[7:0]; alt_oe = d[7:0] ^ 8'h5A;
        wr(1'b0, {8'hFF, d[7:0]});
        @(negedge clk);
        case (m)
          0: check_all("R3 R6 R8 alt", pv);
          1: check_all("R4 R6 R8 drive", pv);
          2: check_all("R5 R7 R8 pull", pv);
          default: check_all("R5 R7 R8 float", pv);
        endcase
      end
    end

    // mixed modes: pins 0..7 take codes 00,01,10,11,00,01,10,11
    wr(1'b1, 16'hE4E4);
    for (int d = 0; d < 256; d += 7) begin
      pv = d[7:0] ^ 8'hA5;
      pin_in = pv; alt_out = d[7:0] + 8'd3; alt_oe = ~d[7:0];
      wr(1'b0, {8'h00, d[7:0]});
      @(negedge clk);
      check_all("R3 R4 R5 R6 R7 mixed", pv);
    end

    // R7 latency: visible after second edge, not first
    wr(1'b1, 16'hFFFF);
    pin_in = 8'h00; repeat (2) @(negedge clk);
    pin_in = 8'hFF;
    @(negedge clk); bus_sel = 1'b0; #1;
    chk("R7 one edge", bus_rdata, 16'h0000);
    @(negedge clk); #1;
    chk("R7 two edges", bus_rdata, 16'h00FF);

    // concurrent latch write and pin change in input mode, then R9 switch
    wr(1'b1, 16'hAAAA);
    pin_in = 8'h00; repeat (2) @(negedge clk);
    pin_in = 8'hA5;
    wr(1'b0, 16'h003C);
    @(negedge clk);
    check_all("R8 R7 concurrent", 8'hA5);
    wr(1'b1, 16'h5555);
    #1;
    chk("R9 pin_out", {8'h00, pin_out}, 16'h003C);
    chk("R9 read", bus_rdata, 16'h003C);
    chk("R9 pin_oe", {8'h00, pin_oe}, 16'h00FF);

    summary();
    $finish;
  end

endmodule